// File: doc/BRIEF.md
# Age-Ordered Crossbar Target Arbiter

This block sits at one destination of a processor-to-cache switch: one instance per cache bank and one more for the system interface port. Each of the requesting cores may raise a level request toward this destination. The request comes with an 8-byte write payload. The arbiter remembers the order in which requests arrived and always grants the one that has waited longest. Requests that arrive on the same clock edge are ordered by source index, with the lower index counted as older.

The work is split into three registered steps. A request is captured into a pending set, together with its payload. On a later edge the oldest pending source is chosen into a selection register. On the edge after that the grant is driven back to that core. One cycle after the grant, the stored payload is presented to the destination with a valid strobe. The destination can stall the pipeline with a ready input. Because each destination has its own instance, different destinations grant in parallel without affecting one another.

Top module: `age_ordered_target_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `gnt_o` is all zeros and `dst_valid_o` is low.
- R2: A request from an idle source, with no other pending work and `dst_ready_i` high, is first sampled at clock edge k. Bit s of `gnt_o` is then high during exactly the cycle after edge k+2, and low before that.
- R3: In the cycle after a grant to source s, `dst_valid_o` is high. `dst_data_o` equals the value of slice s of `data_i` (bits s*64 up to s*64+63) sampled at the edge where that request was captured.
- R4: Requests captured on different edges are granted in the order they were captured, whatever their source indices.
- R5: Requests captured on the same edge are granted in ascending source index order.
- R6: At most one bit of `gnt_o` is high in any cycle.
- R7: A grant appears only in a cycle whose preceding edge saw `dst_ready_i` high. While ready is low, pending requests are kept and their relative order does not change.
- R8: From the edge that captures a request until the end of its grant cycle, that source's `req_i` and its data slice are ignored. A request still high on the edge after the grant cycle counts as a new request. A source is never granted in two consecutive cycles.
- R9: `dst_valid_o` is high exactly in the cycles that follow a cycle with a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Per-source level request, held until granted |
| data_i | input | NUM_SRC*PAYLOAD_W | Per-source write payload, source s in slice s |
| dst_ready_i | input | 1 | Destination can accept; low stalls selection and grants |
| gnt_o | output | NUM_SRC | One-hot grant back to the chosen source |
| dst_valid_o | output | 1 | Payload strobe toward the destination |
| dst_data_o | output | PAYLOAD_W | Payload of the granted source |

## Verification
The bench targets three hazards: simultaneous arrivals, a late low-index request competing with an earlier high-index one, and a long stall with ready low. An arbiter that ranks by index instead of age would grant the late low-index source first. One that lost order during a stall would reorder the queue once ready returns. The bench also changes a waiting source's payload, and keeps a request high through its grant cycle. A design that re-captured on either would send the wrong payload or grant the same core twice. A long random phase compares every cycle against a behavioural queue model in the bench.

// File: rtl/age_arb_pkg.sv
package age_arb_pkg;
  localparam int DEF_NUM_SRC   = 8;
  localparam int DEF_PAYLOAD_W = 64;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tgt_age_matrix.sv
module tgt_age_matrix #(
  parameter int NUM_SRC = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SRC-1:0]                cap_i,
  input  logic [NUM_SRC-1:0]                pend_i,
  output logic [NUM_SRC-1:0][NUM_SRC-1:0]   older_o
);
  // older_o[r][c] = 1 means source r arrived before source c
  logic [NUM_SRC-1:0][NUM_SRC-1:0] older_d;

  always_comb begin
    older_d = older_o;
    for (int r = 0; r < NUM_SRC; r++) begin
      for (int c = 0; c < NUM_SRC; c++) begin
        if (r == c) begin
          older_d[r][c] = 1'b0;
        end else if (cap_i[r]) begin
          // same-edge arrivals: lower index is older; else younger than all pending
          older_d[r][c] = cap_i[c] ? (r < c) : ~pend_i[c];
        end else if (cap_i[c]) begin
          older_d[r][c] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) older_o <= '0;
    else     older_o <= older_d;
  end
endmodule

// File: rtl/tgt_oldest_pick.sv
module tgt_oldest_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = age_arb_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]               pend_i,
  input  logic [NUM_SRC-1:0][NUM_SRC-1:0]  older_i,
  output logic                             win_valid_o,
  output logic [IDX_W-1:0]                 win_idx_o,
  output logic [NUM_SRC-1:0]               win_oh_o
);
  always_comb begin
    win_oh_o  = '0;
    win_idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      logic beats_all;
      beats_all = pend_i[i];
      for (int j = 0; j < NUM_SRC; j++) begin
        if (j != i && pend_i[j] && !older_i[i][j]) beats_all = 1'b0;
      end
      win_oh_o[i] = beats_all;
      if (beats_all) win_idx_o = IDX_W'(i);
    end
    win_valid_o = |win_oh_o;
  end
endmodule

// File: rtl/tgt_payload_buf.sv
module tgt_payload_buf #(
  parameter int NUM_SRC   = 8,
  parameter int PAYLOAD_W = 64,
  localparam int IDX_W    = age_arb_pkg::idx_width(NUM_SRC)
) (
  input  logic                           clk,
  input  logic [NUM_SRC-1:0]             wr_en_i,
  input  logic [NUM_SRC*PAYLOAD_W-1:0]   wr_data_i,
  input  logic [IDX_W-1:0]               rd_idx_i,
  output logic [PAYLOAD_W-1:0]           rd_data_o
);
  logic [PAYLOAD_W-1:0] slot [NUM_SRC];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SRC; s++) begin
      if (wr_en_i[s]) slot[s] <= wr_data_i[s*PAYLOAD_W +: PAYLOAD_W];
    end
    rd_data_o <= slot[rd_idx_i];
  end
endmodule

// File: rtl/age_ordered_target_arb.sv
module age_ordered_target_arb #(
  parameter int NUM_SRC   = age_arb_pkg::DEF_NUM_SRC,
  parameter int PAYLOAD_W = age_arb_pkg::DEF_PAYLOAD_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC*PAYLOAD_W-1:0]   data_i,
  input  logic                           dst_ready_i,
  output logic [NUM_SRC-1:0]             gnt_o,
  output logic                           dst_valid_o,
  output logic [PAYLOAD_W-1:0]           dst_data_o
);
  localparam int IDX_W = age_arb_pkg::idx_width(NUM_SRC);

  logic [NUM_SRC-1:0]              pend_q;
  logic                            sel_valid_q;
  logic [IDX_W-1:0]                sel_idx_q;
  logic [IDX_W-1:0]                gnt_idx_q;
  logic [NUM_SRC-1:0]              sel_mask;
  logic [NUM_SRC-1:0]              busy;
  logic [NUM_SRC-1:0]              cap;
  logic [NUM_SRC-1:0][NUM_SRC-1:0] older;
  logic                            win_valid;
  logic [IDX_W-1:0]                win_idx;
  logic [NUM_SRC-1:0]              win_oh;

  // stage 1: capture requests from sources with nothing in flight
  always_comb begin
    sel_mask = '0;
    if (sel_valid_q) sel_mask[sel_idx_q] = 1'b1;
  end
  assign busy = pend_q | sel_mask | gnt_o;
  assign cap  = req_i & ~busy;

  tgt_age_matrix #(.NUM_SRC(NUM_SRC)) u_age (
    .clk     (clk),
    .rst     (rst),
    .cap_i   (cap),
    .pend_i  (pend_q),
    .older_o (older)
  );

  // stage 2: pick the oldest pending source
  tgt_oldest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i      (pend_q),
    .older_i     (older),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_oh_o    (win_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      sel_valid_q <= 1'b0;
      sel_idx_q   <= '0;
      gnt_o       <= '0;
      gnt_idx_q   <= '0;
      dst_valid_o <= 1'b0;
    end else begin
      dst_valid_o <= |gnt_o;
      if (dst_ready_i) begin
        // stage 3: grant what was selected, refill selection
        gnt_o       <= sel_mask;
        gnt_idx_q   <= sel_idx_q;
        sel_valid_q <= win_valid;
        sel_idx_q   <= win_idx;
        pend_q      <= (pend_q & ~win_oh) | cap;
      end else begin
        gnt_o  <= '0;
        pend_q <= pend_q | cap;
      end
    end
  end

  // payload store and output mux
  tgt_payload_buf #(.NUM_SRC(NUM_SRC), .PAYLOAD_W(PAYLOAD_W)) u_buf (
    .clk       (clk),
    .wr_en_i   (cap),
    .wr_data_i (data_i),
    .rd_idx_i  (gnt_idx_q),
    .rd_data_o (dst_data_o)
  );
endmodule

// File: rtl/age_ordered_target_arb_chk.sv
module age_ordered_target_arb_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_i,
  input logic               dst_ready_i,
  input logic [NUM_SRC-1:0] gnt_o,
  input logic               dst_valid_o
);
  // R6
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  // R7
  gnt_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (|gnt_o) |-> $past(dst_ready_i));

  // R9
  valid_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (|gnt_o) |=> dst_valid_o);

  // R9
  idle_after_none_chk: assert property (@(posedge clk) disable iff (rst)
    !(|gnt_o) |=> !dst_valid_o);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      // R8
      no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_o[s] |=> !gnt_o[s]);

      // R2
      gnt_had_req_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_o[s] |-> $past(req_i[s], 3));
    end
  endgenerate
endmodule

bind age_ordered_target_arb age_ordered_target_arb_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .dst_ready_i (dst_ready_i),
  .gnt_o       (gnt_o),
  .dst_valid_o (dst_valid_o)
);

// File: tb/age_ordered_target_arb_tb.sv
module age_ordered_target_arb_tb;
  localparam int N          = 8;
  localparam int W          = 64;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst;
  logic [N-1:0]   req;
  logic [N*W-1:0] data;
  logic           ready;
  logic [N-1:0]   gnt;
  logic           dvalid;
  logic [W-1:0]   ddata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit auto_drop = 1;
  string cur_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  age_ordered_target_arb #(.NUM_SRC(N), .PAYLOAD_W(W)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .data_i(data), .dst_ready_i(ready),
    .gnt_o(gnt), .dst_valid_o(dvalid), .dst_data_o(ddata)
  );

  // behavioural model: FIFO of captured sources
  int           q_src[$];
  logic [W-1:0] m_buf [N];
  logic [N-1:0] m_inq, m_gnt;
  logic         m_selv, m_valid;
  int           m_sel, m_gidx;
  logic [W-1:0] m_data;

  always @(posedge clk) begin
    if (rst) begin
      q_src.delete();
      m_inq = '0; m_gnt = '0; m_selv = 0; m_sel = 0; m_valid = 0; m_gidx = 0;
    end else begin
      logic [N-1:0] busy;
      busy = m_inq | m_gnt;
      if (m_selv) busy[m_sel] = 1'b1;
      m_valid = |m_gnt;
      if (m_valid) m_data = m_buf[m_gidx];
      if (ready) begin
        m_gnt = '0;
        if (m_selv) begin m_gnt[m_sel] = 1'b1; m_gidx = m_sel; end
        if (q_src.size() > 0) begin
          m_sel = q_src.pop_front(); m_selv = 1; m_inq[m_sel] = 1'b0;
        end else m_selv = 0;
      end else m_gnt = '0;
      for (int s = 0; s < N; s++) begin
        if (req[s] && !busy[s]) begin
          q_src.push_back(s); m_inq[s] = 1'b1; m_buf[s] = data[s*W +: W];
        end
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_tag, gnt === m_gnt, "grant vector", W'(gnt), W'(m_gnt));
    chk("R9", dvalid === m_valid, "dst_valid", W'(dvalid), W'(m_valid));
    if (m_valid) chk("R3", ddata === m_data, "dst_data", ddata, m_data);
    chk("R6", $countones(gnt) <= 1, "grant popcount", W'($countones(gnt)), 1);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    if (auto_drop) req = req & ~gnt;
  endtask

  task automatic raise(input int s, input logic [W-1:0] v);
    req[s] = 1'b1; data[s*W +: W] = v;
  endtask

  task automatic wait_grant(output logic [N-1:0] g);
    g = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      compare_all();
      g = gnt;
      if (auto_drop) req = req & ~gnt;
      if (g != 0) break;
    end
  endtask

  initial begin
    logic [N-1:0] g;
    void'($urandom(32'h5eed_c0de));
    rst = 1; req = '0; data = '0; ready = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", gnt === '0, "gnt in reset", W'(gnt), 0);
    chk("R1", dvalid === 1'b0, "valid in reset", W'(dvalid), 0);
    rst = 0;
    step();
    chk("R1", gnt === '0 && dvalid === 1'b0, "first cycle after reset", W'(gnt), 0);

    // R2: exact latency of a lone request
    cur_tag = "R2";
    raise(3, 64'hA5A5_0000_1111_0003);
    step(); step();
    chk("R2", gnt === '0, "grant too early", W'(gnt), 0);
    step();
    chk("R2", gnt === 8'b0000_1000, "grant on third edge", W'(gnt), 8'h08);
    step();
    chk("R3", dvalid && ddata === 64'hA5A5_0000_1111_0003, "payload", ddata, 64'hA5A5_0000_1111_0003);
    repeat (3) step();

    // R5: same-edge tie goes to lower index
    cur_tag = "R5";
    raise(5, 64'h55); raise(2, 64'h22);
    wait_grant(g);
    chk("R5", g === 8'b0000_0100, "tie first winner", W'(g), 8'h04);
    wait_grant(g);
    chk("R5", g === 8'b0010_0000, "tie second winner", W'(g), 8'h20);
    repeat (3) step();

    // R4: earlier high index beats later low index
    cur_tag = "R4";
    raise(6, 64'h66); step();
    raise(1, 64'h11);
    wait_grant(g);
    chk("R4", g === 8'b0100_0000, "older first", W'(g), 8'h40);
    wait_grant(g);
    chk("R4", g === 8'b0000_0010, "younger second", W'(g), 8'h02);
    repeat (3) step();

    // R7: stall with ready low
    cur_tag = "R7";
    ready = 0;
    raise(4, 64'h44); step();
    raise(0, 64'h0F);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R7", gnt === '0, "grant while stalled", W'(gnt), 0);
    end
    ready = 1;
    wait_grant(g);
    chk("R7", g === 8'b0001_0000, "order kept over stall", W'(g), 8'h10);
    wait_grant(g);
    chk("R7", g === 8'b0000_0001, "second after stall", W'(g), 8'h01);
    repeat (3) step();

    // R8: payload change while waiting is ignored; held request re-arms
    cur_tag = "R8";
    auto_drop = 0;
    raise(7, 64'hAAAA);
    step();
    data[7*W +: W] = 64'hBBBB;
    wait_grant(g);
    chk("R8", g === 8'b1000_0000, "grant to 7", W'(g), 8'h80);
    step();
    chk("R8", ddata === 64'hAAAA, "payload frozen at capture", ddata, 64'hAAAA);
    chk("R8", gnt === '0, "no back-to-back grant", W'(gnt), 0);
    req[7] = 1'b0;
    auto_drop = 1;
    repeat (6) step();

    // random traffic against the model
    cur_tag = "R4";
    auto_drop = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare_all();
      ready = ($urandom % 10) < 7;
      for (int s = 0; s < N; s++) begin
        if (gnt[s]) begin
          req[s] = $urandom % 2;
          data[s*W +: W] = {$urandom, $urandom};
        end else if (!req[s]) begin
          if ($urandom % 4 == 0) begin
            req[s] = 1'b1; data[s*W +: W] = {$urandom, $urandom};
          end
        end else if ($urandom % 3 == 0) begin
          data[s*W +: W] = {$urandom, $urandom};
        end
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule